// File: doc/BRIEF.md
# Per-Side Supply Undervoltage Qualifier

This block sits between the raw undervoltage comparators of a half-bridge gate driver and the logic that decides whether each output stage may switch. It takes one comparator bit for the high-side supply and one for the low-side supply. The bits are already synchronised to `clk`. From them it produces a clean supply-valid flag per side. Tripping is asymmetric. A comparator that reports undervoltage withdraws that side's valid flag in the same cycle. Release needs the comparator to stay clear for a programmable number of clock edges, and an optional policy also requires a fresh enable edge before the side is trusted again.

Each side keeps its own trip log: a sticky flag and a saturating 8-bit event counter. Supply chatter during brownout is therefore visible per side, and one side's events are never merged with the other's. A clear pulse per side zeroes its log. The analog thresholds and hysteresis are outside this block.

All pins are plain level-sensitive control and status lines. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure rule.

Top module: `uv_qual_top`

## Requirements
- R1: While a side's raw bit is 1 (undervoltage), that side's ok output is 0 in the same cycle, whatever its state, and the side returns to its invalid state at the next edge.
- R2: Let N be `win_len`, with 0 read as 1. A side leaves the invalid state only after its raw bit has been sampled 0 at N+1 consecutive rising edges. A 1 sampled during that run restarts it.
- R3: The two sides are fully independent. Each has its own state, window counter, ok output, sticky flag and event counter, and one side's raw or clear input never changes the other side's outputs.
- R4: With `reenable_mode` = 0 at the edge that completes the window, ok goes to 1 right after that edge.
- R5: With `reenable_mode` = 1 at the edge that completes the window, the side waits. It is released only at an edge where `drv_enable` is 1 and was 0 at the previous edge, sampled while waiting. Holding enable at 1 does not release it.
- R6: After reset both ok outputs are 0, both flags are 0 and both counters are 0. The first release needs the full window of R2.
- R7: A trip event is a raw bit sampled 1 at an edge after being sampled 0 at the previous edge. Raw is treated as 1 before the first edge after reset. Each event adds one to that side's counter, which holds at 255.
- R8: A side's sticky flag becomes 1 at its first trip event and stays 1 until that side's clear input is used.
- R9: A clear input sampled 1 zeroes that side's counter and flag. A trip event at the same edge is then counted, leaving a count of 1 and the flag at 1.
- R10: A `win_len` of 0 behaves exactly like 1, so the raw bit needs two clear samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_hs_raw | input | 1 | High-side comparator, 1 = undervoltage |
| uv_ls_raw | input | 1 | Low-side comparator, 1 = undervoltage |
| win_len | input | WIN_W | Clear-window length in clock edges (0 treated as 1) |
| reenable_mode | input | 1 | 1 = release waits for an enable rising edge |
| drv_enable | input | 1 | Driver enable line, used for the re-enable edge |
| trip_clr_hs | input | 1 | Clears high-side counter and flag |
| trip_clr_ls | input | 1 | Clears low-side counter and flag |
| ok_hs | output | 1 | High-side supply qualified valid |
| ok_ls | output | 1 | Low-side supply qualified valid |
| uv_flag_hs | output | 1 | High-side sticky trip flag |
| uv_flag_ls | output | 1 | Low-side sticky trip flag |
| trip_cnt_hs | output | CNT_W | High-side saturating trip counter |
| trip_cnt_ls | output | CNT_W | Low-side saturating trip counter |

## Verification
The bench builds the block with its default parameters: a 16-bit window and 8-bit counters. It drives `win_len` at run time with small values, mostly 0 to 6 and once 20. Full windows, restarts caused by glitches and the zero-length case therefore all occur within a few cycles. With the 8-bit counter width, a few hundred forced toggles of one comparator reach saturation. With both sides built from the same parameters, the random phase can show that activity on one side never leaks into the other.

// File: rtl/uvq_pkg.sv
package uvq_pkg;

  typedef enum logic [1:0] {
    ST_INVALID = 2'd0,
    ST_QUAL    = 2'd1,
    ST_WAIT_EN = 2'd2,
    ST_VALID   = 2'd3
  } side_state_e;

  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_HI   = 0;
  localparam int unsigned SIDE_LO   = 1;

endpackage

// File: rtl/uvq_en_edge.sv
module uvq_en_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  output logic en_rise
);

  logic en_q;

  // Previous value resets to 1: an enable already high through reset
  // does not count as a fresh edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_in;
  end

  assign en_rise = en_in & ~en_q;

endmodule

// File: rtl/uvq_side_fsm.sv
module uvq_side_fsm
  import uvq_pkg::*;
#(
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_raw,
  input  logic [WIN_W-1:0] win_len,
  input  logic             reenable_mode,
  input  logic             en_rise,
  output logic             supply_ok,
  output side_state_e      state_o
);

  localparam int unsigned RUN_W = WIN_W + 1;

  side_state_e      state_q, state_d;
  logic [WIN_W-1:0] run_q, run_d;
  logic [RUN_W-1:0] need;
  logic [RUN_W-1:0] run_next;
  logic             win_done;

  // Zero-length window is promoted to one edge.
  always_comb begin
    if (win_len == '0) need = RUN_W'(1);
    else               need = {1'b0, win_len};
  end

  assign run_next = {1'b0, run_q} + RUN_W'(1);
  assign win_done = (run_next >= need);

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    unique case (state_q)
      ST_INVALID: begin
        run_d = '0;
        if (!uv_raw) state_d = ST_QUAL;
      end
      ST_QUAL: begin
        if (uv_raw) begin
          state_d = ST_INVALID;
          run_d   = '0;
        end else if (win_done) begin
          state_d = reenable_mode ? ST_WAIT_EN : ST_VALID;
          run_d   = '0;
        end else begin
          run_d = run_next[WIN_W-1:0];
        end
      end
      ST_WAIT_EN: begin
        if (uv_raw)       state_d = ST_INVALID;
        else if (en_rise) state_d = ST_VALID;
      end
      ST_VALID: begin
        if (uv_raw) state_d = ST_INVALID;
      end
      default: begin
        state_d = ST_INVALID;
        run_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INVALID;
      run_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  // Trip path bypasses the register: undervoltage removes ok at once.
  assign supply_ok = (state_q == ST_VALID) && !uv_raw;
  assign state_o   = state_q;

endmodule

// File: rtl/uvq_trip_log.sv
module uvq_trip_log #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_raw,
  input  logic             clr,
  output logic [CNT_W-1:0] trip_cnt,
  output logic             trip_seen
);

  logic             raw_q;
  logic             trip_evt;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_d;
  logic             seen_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b1;
    else        raw_q <= uv_raw;
  end

  assign trip_evt = uv_raw & ~raw_q;

  always_comb begin
    cnt_base = clr ? '0 : trip_cnt;
    cnt_d    = cnt_base;
    if (trip_evt && !(&cnt_base)) cnt_d = cnt_base + CNT_W'(1);
    seen_d   = (clr ? 1'b0 : trip_seen) | trip_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_cnt  <= '0;
      trip_seen <= 1'b0;
    end else begin
      trip_cnt  <= cnt_d;
      trip_seen <= seen_d;
    end
  end

endmodule

// File: rtl/uv_qual_top.sv
module uv_qual_top
  import uvq_pkg::*;
#(
  parameter int unsigned WIN_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_hs_raw,
  input  logic             uv_ls_raw,
  input  logic [WIN_W-1:0] win_len,
  input  logic             reenable_mode,
  input  logic             drv_enable,
  input  logic             trip_clr_hs,
  input  logic             trip_clr_ls,
  output logic             ok_hs,
  output logic             ok_ls,
  output logic             uv_flag_hs,
  output logic             uv_flag_ls,
  output logic [CNT_W-1:0] trip_cnt_hs,
  output logic [CNT_W-1:0] trip_cnt_ls
);

  logic                 en_rise;
  logic [NUM_SIDES-1:0] raw_v;
  logic [NUM_SIDES-1:0] clr_v;
  logic [NUM_SIDES-1:0] ok_v;
  logic [NUM_SIDES-1:0] seen_v;
  logic [CNT_W-1:0]     cnt_v [NUM_SIDES];
  side_state_e          st_v  [NUM_SIDES];

  assign raw_v[SIDE_HI] = uv_hs_raw;
  assign raw_v[SIDE_LO] = uv_ls_raw;
  assign clr_v[SIDE_HI] = trip_clr_hs;
  assign clr_v[SIDE_LO] = trip_clr_ls;

  uvq_en_edge en_edge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_in   (drv_enable),
    .en_rise (en_rise)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    uvq_side_fsm #(.WIN_W(WIN_W)) fsm_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .uv_raw        (raw_v[s]),
      .win_len       (win_len),
      .reenable_mode (reenable_mode),
      .en_rise       (en_rise),
      .supply_ok     (ok_v[s]),
      .state_o       (st_v[s])
    );

    uvq_trip_log #(.CNT_W(CNT_W)) log_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .uv_raw    (raw_v[s]),
      .clr       (clr_v[s]),
      .trip_cnt  (cnt_v[s]),
      .trip_seen (seen_v[s])
    );
  end

  assign ok_hs       = ok_v[SIDE_HI];
  assign ok_ls       = ok_v[SIDE_LO];
  assign uv_flag_hs  = seen_v[SIDE_HI];
  assign uv_flag_ls  = seen_v[SIDE_LO];
  assign trip_cnt_hs = cnt_v[SIDE_HI];
  assign trip_cnt_ls = cnt_v[SIDE_LO];

endmodule

// File: rtl/uv_qual_chk.sv
module uv_qual_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uv_hs_raw,
  input logic             uv_ls_raw,
  input logic             trip_clr_hs,
  input logic             trip_clr_ls,
  input logic             ok_hs,
  input logic             ok_ls,
  input logic             uv_flag_hs,
  input logic             uv_flag_ls,
  input logic [CNT_W-1:0] trip_cnt_hs,
  input logic [CNT_W-1:0] trip_cnt_ls
);

  // R1: undervoltage removes ok in the same cycle
  a_r1_hs_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_hs_raw |-> !ok_hs);
  a_r1_ls_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_ls_raw |-> !ok_ls);

  // R2: release only after clear samples
  a_r2_hs_clear_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_hs) |-> !$past(uv_hs_raw));
  a_r2_ls_clear_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_ls) |-> !$past(uv_ls_raw));

  // R7: counter never wraps and moves by at most one
  a_r7_hs_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((&trip_cnt_hs) && !trip_clr_hs) |=> (&trip_cnt_hs));
  a_r7_hs_step: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_clr_hs |=> (trip_cnt_hs == $past(trip_cnt_hs) ||
                      trip_cnt_hs == $past(trip_cnt_hs) + 1));
  a_r7_ls_step: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_clr_ls |=> (trip_cnt_ls == $past(trip_cnt_ls) ||
                      trip_cnt_ls == $past(trip_cnt_ls) + 1));

  // R8: a nonzero count implies the sticky flag
  a_r8_hs_flag_with_count: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_cnt_hs != '0) |-> uv_flag_hs);
  a_r8_ls_flag_with_count: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_cnt_ls != '0) |-> uv_flag_ls);

  // R9: clear leaves at most the same-edge event
  a_r9_hs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    trip_clr_hs |=> (trip_cnt_hs <= 1));
  a_r9_ls_clear: assert property (@(posedge clk) disable iff (!rst_n)
    trip_clr_ls |=> (trip_cnt_ls <= 1));

endmodule

bind uv_qual_top uv_qual_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .uv_hs_raw   (uv_hs_raw),
  .uv_ls_raw   (uv_ls_raw),
  .trip_clr_hs (trip_clr_hs),
  .trip_clr_ls (trip_clr_ls),
  .ok_hs       (ok_hs),
  .ok_ls       (ok_ls),
  .uv_flag_hs  (uv_flag_hs),
  .uv_flag_ls  (uv_flag_ls),
  .trip_cnt_hs (trip_cnt_hs),
  .trip_cnt_ls (trip_cnt_ls)
);

// File: tb/uv_qual_top_tb_top.sv
`timescale 1ns/1ps
module uv_qual_top_tb_top;

  localparam int WIN_W = 16;
  localparam int CNT_W = 8;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_hs_raw = 1'b1, uv_ls_raw = 1'b1;
  logic [WIN_W-1:0] win_len = '0;
  logic reenable_mode = 1'b0, drv_enable = 1'b0;
  logic trip_clr_hs = 1'b0, trip_clr_ls = 1'b0;
  logic ok_hs, ok_ls, uv_flag_hs, uv_flag_ls;
  logic [CNT_W-1:0] trip_cnt_hs, trip_cnt_ls;

  always #10 clk = ~clk;

  uv_qual_top #(.WIN_W(WIN_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .uv_hs_raw(uv_hs_raw), .uv_ls_raw(uv_ls_raw),
    .win_len(win_len), .reenable_mode(reenable_mode), .drv_enable(drv_enable),
    .trip_clr_hs(trip_clr_hs), .trip_clr_ls(trip_clr_ls),
    .ok_hs(ok_hs), .ok_ls(ok_ls), .uv_flag_hs(uv_flag_hs), .uv_flag_ls(uv_flag_ls),
    .trip_cnt_hs(trip_cnt_hs), .trip_cnt_ls(trip_cnt_ls)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model of the requirements, advanced once per rising edge.
  int m_run [2];
  bit m_valid [2];
  bit m_wait [2];
  bit m_prev [2];
  bit m_seen [2];
  int m_cnt [2];
  bit m_en_prev;

  function automatic void model_reset();
    for (int s = 0; s < 2; s++) begin
      m_run[s] = 0; m_valid[s] = 0; m_wait[s] = 0;
      m_prev[s] = 1; m_seen[s] = 0; m_cnt[s] = 0;
    end
    m_en_prev = 1;
  endfunction

  function automatic void model_edge(bit raw0, bit raw1, bit clr0, bit clr1,
                                     bit en, int len, bit mode);
    bit raw [2];
    bit clr [2];
    int need;
    raw[0] = raw0; raw[1] = raw1; clr[0] = clr0; clr[1] = clr1;
    need = (len == 0) ? 1 : len;
    for (int s = 0; s < 2; s++) begin
      if (raw[s]) begin
        m_run[s] = 0; m_valid[s] = 0; m_wait[s] = 0;
      end else begin
        if (m_run[s] < 100000) m_run[s]++;
        if (m_wait[s]) begin
          if (en && !m_en_prev) begin m_wait[s] = 0; m_valid[s] = 1; end
        end else if (!m_valid[s] && m_run[s] >= need + 1) begin
          if (mode) m_wait[s] = 1;
          else      m_valid[s] = 1;
        end
      end
      if (clr[s]) begin m_cnt[s] = 0; m_seen[s] = 0; end
      if (raw[s] && !m_prev[s]) begin
        if (m_cnt[s] < CNT_MAX) m_cnt[s]++;
        m_seen[s] = 1;
      end
      m_prev[s] = raw[s];
    end
    m_en_prev = en;
  endfunction

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, got, exp, $time);
    end
  endtask

  // Drive at the falling edge, check after settling, then advance the model.
  task automatic step(string tag, bit rh, bit rl, bit ch, bit cl, bit en,
                      int len, bit mode);
    @(negedge clk);
    uv_hs_raw = rh; uv_ls_raw = rl; trip_clr_hs = ch; trip_clr_ls = cl;
    drv_enable = en; win_len = WIN_W'(len); reenable_mode = mode;
    #1;
    check(tag, "ok_hs", int'(ok_hs), int'(m_valid[0] && !rh));
    check(tag, "ok_ls", int'(ok_ls), int'(m_valid[1] && !rl));
    check("R8", "uv_flag_hs", int'(uv_flag_hs), int'(m_seen[0]));
    check("R8", "uv_flag_ls", int'(uv_flag_ls), int'(m_seen[1]));
    check("R7", "trip_cnt_hs", int'(trip_cnt_hs), m_cnt[0]);
    check("R7", "trip_cnt_ls", int'(trip_cnt_ls), m_cnt[1]);
    @(posedge clk);
    model_edge(rh, rl, ch, cl, en, len, mode);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: reset state, then the first release needs a full window
    #1;
    check("R6", "ok_hs after reset", int'(ok_hs), 0);
    check("R6", "trip_cnt_ls after reset", int'(trip_cnt_ls), 0);
    check("R6", "uv_flag_hs after reset", int'(uv_flag_hs), 0);
    for (int i = 0; i < 6; i++) step("R6", 0, 1, 0, 0, 1, 3, 0);
    check("R6", "ok_hs released after 4 clear edges", int'(ok_hs), 1);

    // R3: low side stays invalid while the high side is valid
    for (int i = 0; i < 4; i++) step("R3", 0, 1, 0, 0, 1, 3, 0);
    check("R3", "ok_ls held invalid", int'(ok_ls), 0);

    // R1: trip on a valid side drops ok in the same cycle
    step("R1", 1, 1, 0, 0, 1, 3, 0);
    check("R1", "ok_hs immediate drop", int'(ok_hs), 0);

    // R10: zero length window needs two clear samples
    for (int i = 0; i < 4; i++) step("R10", 0, 0, 0, 0, 1, 0, 0);

    // R2: glitch inside a window restarts it
    step("R2", 1, 1, 0, 0, 1, 20, 0);
    for (int i = 0; i < 15; i++) step("R2", 0, 0, 0, 0, 1, 20, 0);
    step("R2", 1, 0, 0, 0, 1, 20, 0);
    for (int i = 0; i < 24; i++) step("R2", 0, 0, 0, 0, 1, 20, 0);
    check("R2", "ok_hs after restarted window", int'(ok_hs), 1);

    // R4: automatic release
    step("R4", 1, 1, 0, 0, 0, 2, 0);
    for (int i = 0; i < 5; i++) step("R4", 0, 0, 0, 0, 0, 2, 0);

    // R5: release waits for an enable rising edge
    step("R5", 1, 1, 0, 0, 1, 2, 1);
    for (int i = 0; i < 12; i++) step("R5", 0, 0, 0, 0, 1, 2, 1);
    check("R5", "ok_hs held while enable stays high", int'(ok_hs), 0);
    step("R5", 0, 0, 0, 0, 0, 2, 1);
    step("R5", 0, 0, 0, 0, 1, 2, 1);
    step("R5", 0, 0, 0, 0, 1, 2, 1);
    check("R5", "ok_hs after enable edge", int'(ok_hs), 1);

    // R9: clear alone, then clear together with a trip event
    step("R9", 0, 0, 1, 1, 1, 2, 0);
    step("R9", 0, 0, 0, 0, 1, 2, 0);
    check("R9", "trip_cnt_hs cleared", int'(trip_cnt_hs), 0);
    step("R9", 1, 0, 1, 0, 1, 2, 0);
    step("R9", 1, 0, 0, 0, 1, 2, 0);
    check("R9", "trip_cnt_hs clear with event", int'(trip_cnt_hs), 1);

    // R7: saturation on the high side, low side untouched (R3)
    for (int i = 0; i < 300; i++) begin
      step("R7", 0, 0, 0, 0, 1, 1, 0);
      step("R7", 1, 0, 0, 0, 1, 1, 0);
    end
    check("R7", "trip_cnt_hs saturated", int'(trip_cnt_hs), CNT_MAX);
    check("R3", "trip_cnt_ls untouched by high side", int'(trip_cnt_ls), 0);

    // Constrained random mix
    for (int i = 0; i < 6000; i++) begin
      bit rh, rl, ch, cl, en, md;
      int ln;
      rh = ($urandom_range(0, 9) < 2);
      rl = ($urandom_range(0, 9) < 2);
      ch = ($urandom_range(0, 49) == 0);
      cl = ($urandom_range(0, 49) == 0);
      en = ($urandom_range(0, 3) != 0);
      md = (i >= 3000);
      ln = $urandom_range(0, 6);
      step("R2", rh, rl, ch, cl, en, ln, md);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule